// File: doc/BRIEF.md
# USB Full-Speed Packet Transmit Serializer

This block turns a stream of packet bytes into the line signalling an external full-speed USB transceiver expects. A producer hands over one byte at a time with a valid flag, a marker on the opening byte (the PID) and a marker on the closing byte. A packet-kind input, sampled with the opening byte, says whether a 16-bit checksum must follow the payload. Handshake packets leave it low. Data packets set it high.

The serializer places the sync pattern in front of the packet and shifts every byte out least significant bit first. When the kind input asked for it, it appends the inverted CRC16 of the payload. A single output coder inserts stuff bits and applies NRZI coding. It raises the transceiver output enable with the first sync symbol, closes with an end-of-packet sequence, and then releases the bus.

Each bit time lasts `CLK_PER_BIT` system clocks. The first symbol follows the accepting handshake by two clocks, which keeps the response turnaround short.

Top module: `usb_tx_serializer`

## Requirements
- R1: After reset, `tx_oe` is 0, the line idles at J (`tx_dp`=1, `tx_dn`=0) and `in_ready` is 1.
- R2: Every packet begins with the byte 0x80 sent least significant bit first: seven zero bits, then a one.
- R3: Packet bytes follow the sync pattern in the order they were accepted, each sent least significant bit first.
- R4: When `in_kind_crc` is 1 on the opening byte, the last payload byte is followed by 16 checksum bits. The checksum register uses polynomial 0x8005 and starts at all ones. It covers every byte after the opening byte and excludes the opening byte. The register is inverted and sent with bit 15 first. With no payload, this gives sixteen zero bits.
- R5: When `in_kind_crc` is 0, the end-of-packet sequence follows directly after the last packet byte.
- R6: After every six consecutive one bits, a zero bit is inserted. The checksum bits count toward the run. The stuffed zero carries no packet data.
- R7: NRZI coding: a zero bit changes the line level and a one bit keeps it. The first sync bit is coded against J. J is `tx_dp`=1, `tx_dn`=0 and K is `tx_dp`=0, `tx_dn`=1. Both lines are never high together.
- R8: A packet ends with two bit times of SE0 (`tx_dp`=`tx_dn`=0), then one bit time of J. After that, `tx_oe` returns to 0.
- R9: `tx_oe` rises, carrying the first sync symbol, two clock edges after the edge that accepts the opening byte. Every symbol holds for exactly `CLK_PER_BIT` clocks.
- R10: While no packet is in progress, a byte offered without the opening-byte marker is taken and dropped. The line stays idle, and the next packet is sent normally.
- R11: `in_ready` stays low during the end-of-packet sequence. A new opening byte is only taken once `tx_oe` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_first | input | 1 | Offered byte is the opening byte (PID) |
| in_last | input | 1 | Offered byte is the closing byte |
| in_kind_crc | input | 1 | With opening byte: append CRC16 |
| in_data | input | 8 | Packet byte |
| in_ready | output | 1 | Offered byte is taken on this edge |
| tx_oe | output | 1 | Transceiver output enable |
| tx_dp | output | 1 | D+ drive level |
| tx_dn | output | 1 | D- drive level |

## Verification
The line is compared symbol by symbol against a behavioural model. The test packets are chosen so that each one isolates a different part of the coding:
- A lone handshake byte with no checksum shows that no checksum is added and that the end-of-packet sequence follows at once.
- An empty data packet must close with sixteen zero checksum bits, which shows the PID is left out of the checksum.
- A short counting payload checks bit order and the checksum value.
- A run of 0xFF bytes stresses stuffing.
- A payload chosen so that long one runs reach into the checksum shows that the run count carries across the boundary into the checksum bits.
- Stray bytes without the opening marker, followed by a packet offered back to back with the previous one, separate the drop rule from the rule for when a new packet may start.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE,
        SRC_SYNC,
        SRC_DATA,
        SRC_CRC
    } src_phase_e;

    typedef enum logic [2:0] {
        LC_IDLE,
        LC_DATA,
        LC_SE0_A,
        LC_SE0_B,
        LC_EOP_J
    } lc_state_e;

    typedef struct packed {
        logic oe;
        logic se0;
        logic lvl;
    } line_sym_t;

    localparam logic [7:0]  SYNC_BYTE  = 8'h80;
    localparam logic [15:0] CRC16_POLY = 16'h8005;
    localparam logic [15:0] CRC16_INIT = 16'hFFFF;
    localparam int          STUFF_RUN  = 6;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = b ^ c[15];
        return {c[14:0], 1'b0} ^ (fb ? CRC16_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/usb_tx_bittimer.sv
module usb_tx_bittimer #(
    parameter int CLK_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (CLK_PER_BIT <= 1) begin : g_every
            assign tick = run;
        end else begin : g_div
            localparam int CW = $clog2(CLK_PER_BIT);
            localparam logic [CW-1:0] LAST = CW'(CLK_PER_BIT - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run)
                    cnt <= '0;
                else if (cnt == LAST)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            assign tick = run && (cnt == '0);
        end
    endgenerate
endmodule

// File: rtl/usb_tx_bitsource.sv
module usb_tx_bitsource
    import usb_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_first,
    input  logic       in_last,
    input  logic       in_kind_crc,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       line_idle,
    input  logic       bit_take,
    output logic       bit_valid,
    output logic       bit_val,
    output logic       busy
);
    src_phase_e  phase;
    logic [15:0] sh;
    logic [3:0]  cnt;
    logic [7:0]  pend_d;
    logic        pend_v;
    logic        pend_last;
    logic        cur_last;
    logic        cur_pid;
    logic        crc_en;
    logic        last_seen;
    logic [15:0] crc;
    logic [15:0] crc_nxt;
    logic        accept;
    logic        byte_done;

    assign busy      = (phase != SRC_IDLE);
    assign bit_valid = busy;
    assign bit_val   = (phase == SRC_CRC) ? sh[15] : sh[0];
    assign in_ready  = (phase == SRC_IDLE) ? line_idle
                                           : ((phase != SRC_CRC) && !pend_v && !last_seen);
    assign accept    = in_valid && in_ready;
    assign byte_done = (cnt == 4'd7);
    assign crc_nxt   = ((phase == SRC_DATA) && !cur_pid && crc_en)
                       ? crc16_step(crc, sh[0]) : crc;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= SRC_IDLE;
            sh        <= '0;
            cnt       <= '0;
            pend_d    <= '0;
            pend_v    <= 1'b0;
            pend_last <= 1'b0;
            cur_last  <= 1'b0;
            cur_pid   <= 1'b0;
            crc_en    <= 1'b0;
            last_seen <= 1'b0;
            crc       <= CRC16_INIT;
        end else if (phase == SRC_IDLE) begin
            if (accept && in_first) begin
                pend_d    <= in_data;
                pend_v    <= 1'b1;
                pend_last <= in_last;
                last_seen <= in_last;
                crc_en    <= in_kind_crc;
                crc       <= CRC16_INIT;
                sh        <= {8'h00, SYNC_BYTE};
                cnt       <= '0;
                phase     <= SRC_SYNC;
            end
        end else begin
            if (accept) begin
                pend_d    <= in_data;
                pend_v    <= 1'b1;
                pend_last <= in_last;
                last_seen <= in_last;
            end
            if (bit_take) begin
                if (phase == SRC_CRC) begin
                    sh  <= {sh[14:0], 1'b0};
                    cnt <= cnt + 1'b1;
                    if (cnt == 4'd15)
                        phase <= SRC_IDLE;
                end else begin
                    crc <= crc_nxt;
                    sh  <= {1'b0, sh[15:1]};
                    cnt <= cnt + 1'b1;
                    if (byte_done) begin
                        cnt <= '0;
                        if ((phase == SRC_SYNC) || !cur_last) begin
                            sh       <= {8'h00, pend_d};
                            cur_last <= pend_last;
                            cur_pid  <= (phase == SRC_SYNC);
                            pend_v   <= 1'b0;
                            phase    <= SRC_DATA;
                        end else if (crc_en) begin
                            sh    <= ~crc_nxt;
                            phase <= SRC_CRC;
                        end else begin
                            phase <= SRC_IDLE;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/usb_tx_linecoder.sv
module usb_tx_linecoder
    import usb_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      bit_valid,
    input  logic      bit_val,
    output logic      bit_take,
    output line_sym_t sym,
    output logic      idle
);
    lc_state_e  state;
    logic [2:0] ones;
    logic       stuff_now;

    assign stuff_now = (ones == 3'(STUFF_RUN));
    assign idle      = (state == LC_IDLE);
    assign bit_take  = tick && bit_valid &&
                       ((state == LC_IDLE) || ((state == LC_DATA) && !stuff_now));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LC_IDLE;
            ones  <= '0;
            sym   <= '{oe: 1'b0, se0: 1'b0, lvl: 1'b1};
        end else if (tick) begin
            unique case (state)
                LC_IDLE: begin
                    if (bit_valid) begin
                        sym.oe  <= 1'b1;
                        sym.se0 <= 1'b0;
                        sym.lvl <= bit_val ? sym.lvl : ~sym.lvl;
                        ones    <= bit_val ? 3'd1 : 3'd0;
                        state   <= LC_DATA;
                    end
                end
                LC_DATA: begin
                    if (stuff_now) begin
                        sym.lvl <= ~sym.lvl;
                        ones    <= '0;
                    end else if (bit_valid) begin
                        sym.lvl <= bit_val ? sym.lvl : ~sym.lvl;
                        ones    <= bit_val ? ones + 1'b1 : 3'd0;
                    end else begin
                        sym.se0 <= 1'b1;
                        state   <= LC_SE0_A;
                    end
                end
                LC_SE0_A: state <= LC_SE0_B;
                LC_SE0_B: begin
                    sym.se0 <= 1'b0;
                    sym.lvl <= 1'b1;
                    state   <= LC_EOP_J;
                end
                LC_EOP_J: begin
                    sym.oe <= 1'b0;
                    ones   <= '0;
                    state  <= LC_IDLE;
                end
                default: state <= LC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
    import usb_tx_pkg::*;
#(
    parameter int CLK_PER_BIT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_first,
    input  logic       in_last,
    input  logic       in_kind_crc,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       tx_oe,
    output logic       tx_dp,
    output logic       tx_dn
);
    logic      bit_tick;
    logic      src_busy;
    logic      lc_idle;
    logic      bit_valid;
    logic      bit_val;
    logic      bit_take;
    line_sym_t sym;

    usb_tx_bittimer #(.CLK_PER_BIT(CLK_PER_BIT)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (src_busy || !lc_idle),
        .tick (bit_tick)
    );

    usb_tx_bitsource u_src (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_first    (in_first),
        .in_last     (in_last),
        .in_kind_crc (in_kind_crc),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .line_idle   (lc_idle),
        .bit_take    (bit_take),
        .bit_valid   (bit_valid),
        .bit_val     (bit_val),
        .busy        (src_busy)
    );

    usb_tx_linecoder u_coder (
        .clk       (clk),
        .rst       (rst),
        .tick      (bit_tick),
        .bit_valid (bit_valid),
        .bit_val   (bit_val),
        .bit_take  (bit_take),
        .sym       (sym),
        .idle      (lc_idle)
    );

    assign tx_oe = sym.oe;
    assign tx_dp = sym.lvl & ~sym.se0;
    assign tx_dn = ~sym.lvl & ~sym.se0;
endmodule

// File: rtl/usb_tx_checker.sv
module usb_tx_checker (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic tx_oe,
    input logic tx_dp,
    input logic tx_dn,
    input logic bit_tick
);
    logic       tick_d;
    logic       prev_lvl;
    logic [2:0] run;

    // Length of the current stretch of unchanged line levels, counted per new symbol.
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_d   <= 1'b0;
            prev_lvl <= 1'b1;
            run      <= '0;
        end else begin
            tick_d <= bit_tick;
            if (tick_d) begin
                if (!tx_oe || (!tx_dp && !tx_dn))
                    run <= '0;
                else if (tx_dp == prev_lvl)
                    run <= (run == 3'd7) ? 3'd7 : run + 1'b1;
                else
                    run <= '0;
                prev_lvl <= tx_dp;
            end
        end
    end

    assert_no_se1_R7: assert property (@(posedge clk) disable iff (rst)
        !(tx_dp && tx_dn));

    assert_first_sym_k_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_oe) |-> (!tx_dp && tx_dn));

    assert_release_after_j_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_oe) |-> ($past(tx_dp) && !$past(tx_dn)));

    assert_no_ready_in_eop_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_oe && !tx_dp && !tx_dn) |-> !in_ready);

    assert_run_limit_R6: assert property (@(posedge clk) disable iff (rst)
        run <= 3'd6);

    assert_sym_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable({tx_oe, tx_dp, tx_dn}));
endmodule

bind usb_tx_serializer usb_tx_checker u_chk (.*);

// File: tb/sim_usb_tx_serializer.sv
`timescale 1ns/1ps
module sim_usb_tx_serializer;
    localparam int CPB = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic       in_kind_crc = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       tx_oe;
    logic       tx_dp;
    logic       tx_dn;

    int tests = 0;
    int fails = 0;
    int ncyc  = 0;
    int t_first = 0;

    logic [2:0] exp_sym[$];
    string      exp_tag[$];

    always #2 clk = ~clk;
    always @(negedge clk) ncyc <= ncyc + 1;

    usb_tx_serializer #(.CLK_PER_BIT(CPB)) u0 (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural model: bit list, stuffing, NRZI, end of packet.
    task automatic build(input logic [7:0] pkt[$], input bit with_crc);
        bit    bits[$];
        string tg[$];
        int    crc;
        int    ones;
        bit    lvl;
        exp_sym.delete();
        exp_tag.delete();
        for (int i = 0; i < 8; i++) begin
            bits.push_back(i == 7); tg.push_back("R2");
        end
        foreach (pkt[k])
            for (int i = 0; i < 8; i++) begin
                bits.push_back(pkt[k][i]); tg.push_back("R3");
            end
        if (with_crc) begin
            // reflected form of the checksum, sent low bit first
            crc = 'hFFFF;
            for (int k = 1; k < pkt.size(); k++)
                for (int i = 0; i < 8; i++) begin
                    if (((crc ^ pkt[k][i]) & 1) != 0) crc = (crc >> 1) ^ 'hA001;
                    else crc = crc >> 1;
                end
            crc = ~crc & 'hFFFF;
            for (int i = 0; i < 16; i++) begin
                bits.push_back(crc[i]); tg.push_back("R4");
            end
        end
        ones = 0;
        lvl  = 1'b1;
        foreach (bits[k]) begin
            if (!bits[k]) lvl = ~lvl;
            exp_sym.push_back({1'b1, lvl, ~lvl}); exp_tag.push_back(tg[k]); // R7
            ones = bits[k] ? ones + 1 : 0;
            if (ones == 6) begin
                lvl = ~lvl;
                exp_sym.push_back({1'b1, lvl, ~lvl}); exp_tag.push_back("R6");
                ones = 0;
            end
        end
        exp_sym.push_back(3'b100); exp_tag.push_back(with_crc ? "R8" : "R5");
        exp_sym.push_back(3'b100); exp_tag.push_back("R8");
        exp_sym.push_back(3'b110); exp_tag.push_back("R8");
    endtask

    task automatic produce(input logic [7:0] pkt[$], input bit with_crc);
        foreach (pkt[k]) begin
            @(negedge clk);
            in_valid    = 1'b1;
            in_first    = (k == 0);
            in_last     = (k == pkt.size() - 1);
            in_kind_crc = with_crc;
            in_data     = pkt[k];
            while (!in_ready) @(negedge clk);
            if (k == 0) t_first = ncyc;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic monitor();
        int  waited;
        bit  ok;
        logic [2:0] got;
        waited = 0;
        @(negedge clk);
        while (!tx_oe && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check(ncyc == t_first + 2, "R9", "first symbol cycle", ncyc, t_first + 2);
        foreach (exp_sym[k]) begin
            ok  = 1'b1;
            got = exp_sym[k];
            for (int c = 0; c < CPB; c++) begin
                if (k != 0 || c != 0) @(negedge clk);
                if ({tx_oe, tx_dp, tx_dn} != exp_sym[k]) begin
                    ok  = 1'b0;
                    got = {tx_oe, tx_dp, tx_dn};
                end
                if (exp_sym[k] == 3'b100 && in_ready) ok = 1'b0; // R11
            end
            check(ok, exp_tag[k], $sformatf("symbol %0d {oe,dp,dn}", k), got, exp_sym[k]);
        end
        @(negedge clk);
        check(!tx_oe, "R8", "oe after EOP", tx_oe, 0);
    endtask

    task automatic send(input logic [7:0] pkt[$], input bit with_crc);
        build(pkt, with_crc);
        fork
            produce(pkt, with_crc);
            monitor();
        join
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] p[$];
        bit quiet;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!tx_oe && tx_dp && !tx_dn, "R1", "idle line {oe,dp,dn}",
              {tx_oe, tx_dp, tx_dn}, 3'b010);
        check(in_ready, "R1", "ready after reset", in_ready, 1);

        p = '{8'hD2};                     send(p, 1'b0); // handshake, R5
        p = '{8'hC3};                     send(p, 1'b1); // empty data, R4
        p = '{8'h4B, 8'h00, 8'h01, 8'h02, 8'h03}; send(p, 1'b1); // R3 R4
        p = '{8'hC3, 8'hFF, 8'hFF, 8'hFF};  send(p, 1'b1); // R6
        p = '{8'h69, 8'h7F, 8'hFE, 8'hFC};  send(p, 1'b0); // R6 without checksum
        p = '{8'h4B, 8'hFF, 8'hFF, 8'hA5, 8'h3C}; send(p, 1'b1); // R6 into checksum

        // R10: stray bytes without the opening marker
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            in_valid = 1'b1; in_first = 1'b0; in_last = (s == 2); in_data = 8'hAA;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        quiet = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (tx_oe || !tx_dp || tx_dn) quiet = 1'b0;
        end
        check(quiet, "R10", "line idle after stray bytes", tx_oe, 0);
        check(in_ready, "R10", "ready after stray bytes", in_ready, 1);

        p = '{8'hC3, 8'h12, 8'h34};         send(p, 1'b1); // R10 recovery
        // R11: next packet offered right away; must wait for release
        p = '{8'h5A};                        send(p, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule